// File: doc/BRIEF.md
# Sequential Buffer Fill Controller

This block runs one fill of a small pointer-based buffer from an external word source and then hands control to a processing phase. After a start request it repeats a fixed cycle. It waits a set number of cycles for the source and then spends one read cycle. In that read cycle it pulses a read-acknowledge strobe toward the source and, in the same cycle, enables the buffer with the direction set to write. Between reads it steps the source address by one.

The buffer keeps its own pointer and raises a completion flag from a register, so the flag appears one clock after the last enabled write, or later. The controller does not poll that flag during the fill. It counts its own writes, and after the last one it parks in a hold state that issues no enable and no address step. It stays there until the flag arrives. It then pulses the buffer clear for one cycle, loads a pipeline-delay counter and enters the processing state.

All control outputs are decoded from the registered state, and the state changes only on the rising clock edge. The data path from source to buffer lies outside the block. There is no valid/ready interface: the source is taken to be ready after the fixed gap, so neither side can apply back-pressure. One fill runs per reset.

Top module: `buf_fill_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `src_addr_o` is 0 and `pipe_cnt_o` is 0. In the same cycles `rd_ack_o`, `buf_en_o`, `buf_wr_o`, `buf_clr_o`, `busy_o` and `proc_o` are all low.
- R2: A high `start` seen in the idle state begins a fill. `busy_o` is high from the next cycle until the processing state is reached. Each read is preceded by exactly WAIT_CYC gap cycles.
- R3: A read lasts one cycle. In that cycle `rd_ack_o`, `buf_en_o` and `buf_wr_o` are all 1, where `buf_wr_o` = 1 means write into the buffer. `buf_en_o` is never high without `rd_ack_o`.
- R4: The first read uses address 0, and each later read uses the previous address plus one. The address holds steady between reads, so the addresses run from 0 to DEPTH-1 with no duplicate.
- R5: Exactly DEPTH enabled writes occur per fill. No enable is driven while `fill_done_i` is high.
- R6: After the last write the controller holds, with no strobes and the address unchanged, for as many cycles as `fill_done_i` takes to rise. The hold lasts one cycle when the flag lags the write by one clock, and L+1 cycles when the flag arrives L clocks later than that.
- R7: `buf_clr_o` is high for exactly one cycle per fill. That cycle follows the first cycle in which `fill_done_i` was seen high during the hold.
- R8: After the clear cycle `proc_o` is high and `busy_o` is low. `pipe_cnt_o` starts at PIPE_DLY, falls by one per cycle and then stays at 0.
- R9: `start` has no effect outside the idle state, whether during a fill or in the processing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a fill when the controller is idle |
| fill_done_i | input | 1 | Registered completion flag from the buffer |
| src_addr_o | output | ADDR_W | Word address toward the source |
| rd_ack_o | output | 1 | Read-acknowledge strobe toward the source |
| buf_en_o | output | 1 | Buffer access enable |
| buf_wr_o | output | 1 | Buffer direction, 1 = write |
| buf_clr_o | output | 1 | Buffer pointer and flag clear |
| busy_o | output | 1 | Fill in progress |
| proc_o | output | 1 | Processing state reached |
| pipe_cnt_o | output | clog2(PIPE_DLY+1) | Pipeline-delay counter |

## Verification
The bound checker watches several properties on every clock:
- the read strobes come as a group;
- each read address is one above the one before, and the first is 0;
- each read follows exactly WAIT_CYC gap cycles;
- no write goes past DEPTH and none is enabled under a raised flag;
- each clear follows a seen flag, lasts one cycle and leads into processing;
- the delay counter falls correctly.

Only the bench scenarios show the outcomes that span a whole fill. These are a flag that arrives late, so the hold lasts several cycles, and start pulses that are ignored mid-fill and in processing. They also include the totals of DEPTH unique writes and a single clear, checked against a behavioural buffer model.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GAP   = 3'd1,
    ST_READ  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_CLEAR = 3'd4,
    ST_PROC  = 3'd5
  } bfc_state_e;
endpackage

// File: rtl/bfc_seq.sv
module bfc_seq
  import bfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       fill_done_i,
  input  logic       gap_zero,
  input  logic       last_write,
  output bfc_state_e state_q,
  output logic       gap_load,
  output logic       addr_step,
  output logic       wr_take,
  output logic       pipe_load
);
  bfc_state_e state_d;

  always_comb begin
    state_d   = state_q;
    gap_load  = 1'b0;
    addr_step = 1'b0;
    wr_take   = 1'b0;
    pipe_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_GAP;
          gap_load = 1'b1;
        end
      end
      ST_GAP: begin
        if (gap_zero) state_d = ST_READ;
      end
      ST_READ: begin
        wr_take = 1'b1;
        if (last_write) begin
          state_d = ST_HOLD;
        end else begin
          addr_step = 1'b1;
          gap_load  = 1'b1;
          state_d   = ST_GAP;
        end
      end
      ST_HOLD: begin
        if (fill_done_i) state_d = ST_CLEAR;
      end
      ST_CLEAR: begin
        pipe_load = 1'b1;
        state_d   = ST_PROC;
      end
      ST_PROC: state_d = ST_PROC;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/bfc_downcnt.sv
module bfc_downcnt #(
  parameter int LOAD_VAL = 3,
  localparam int CW = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  output logic [CW-1:0] cnt_q,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load)                 cnt_q <= CW'(LOAD_VAL);
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bfc_addr_gen.sv
module bfc_addr_gen #(
  parameter int DEPTH  = 20,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              take,
  output logic [ADDR_W-1:0] addr_q,
  output logic              last_write
);
  logic [CNT_W-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wcnt_q <= '0;
    end else begin
      if (step) addr_q <= addr_q + ADDR_W'(1);
      if (take) wcnt_q <= wcnt_q + CNT_W'(1);
    end
  end

  assign last_write = (wcnt_q == CNT_W'(DEPTH - 1));
endmodule

// File: rtl/buf_fill_ctrl.sv
module buf_fill_ctrl
  import bfc_pkg::*;
#(
  parameter int DEPTH    = 20,
  parameter int ADDR_W   = 8,
  parameter int WAIT_CYC = 3,
  parameter int PIPE_DLY = 5,
  localparam int PIPE_W  = $clog2(PIPE_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fill_done_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              rd_ack_o,
  output logic              buf_en_o,
  output logic              buf_wr_o,
  output logic              buf_clr_o,
  output logic              busy_o,
  output logic              proc_o,
  output logic [PIPE_W-1:0] pipe_cnt_o
);
  localparam int GAP_LOAD = WAIT_CYC - 1;
  localparam int GAP_W    = (GAP_LOAD < 1) ? 1 : $clog2(GAP_LOAD + 1);

  bfc_state_e       state_q;
  logic             gap_load, addr_step, wr_take, pipe_load;
  logic             gap_zero, last_write, pipe_zero;
  logic [GAP_W-1:0] gap_cnt;

  bfc_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .fill_done_i(fill_done_i),
    .gap_zero   (gap_zero),
    .last_write (last_write),
    .state_q    (state_q),
    .gap_load   (gap_load),
    .addr_step  (addr_step),
    .wr_take    (wr_take),
    .pipe_load  (pipe_load)
  );

  bfc_downcnt #(.LOAD_VAL(GAP_LOAD)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (gap_load),
    .run  (state_q == ST_GAP),
    .cnt_q(gap_cnt),
    .zero (gap_zero)
  );

  bfc_downcnt #(.LOAD_VAL(PIPE_DLY)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .load (pipe_load),
    .run  (state_q == ST_PROC),
    .cnt_q(pipe_cnt_o),
    .zero (pipe_zero)
  );

  bfc_addr_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .step      (addr_step),
    .take      (wr_take),
    .addr_q    (src_addr_o),
    .last_write(last_write)
  );

  // Moore decode: every strobe follows the registered state only
  always_comb begin
    rd_ack_o  = 1'b0;
    buf_en_o  = 1'b0;
    buf_wr_o  = 1'b0;
    buf_clr_o = 1'b0;
    busy_o    = 1'b0;
    proc_o    = 1'b0;
    case (state_q)
      ST_GAP:   busy_o = 1'b1;
      ST_READ: begin
        busy_o   = 1'b1;
        rd_ack_o = 1'b1;
        buf_en_o = 1'b1;
        buf_wr_o = 1'b1;
      end
      ST_HOLD:  busy_o = 1'b1;
      ST_CLEAR: begin
        busy_o    = 1'b1;
        buf_clr_o = 1'b1;
      end
      ST_PROC:  proc_o = 1'b1;
      default:  ;
    endcase
  end

  logic unused_ok;
  assign unused_ok = ^{gap_cnt, pipe_zero};
endmodule

// File: rtl/bfc_checker.sv
module bfc_checker #(
  parameter int DEPTH    = 20,
  parameter int ADDR_W   = 8,
  parameter int WAIT_CYC = 3,
  parameter int PIPE_DLY = 5,
  localparam int PIPE_W  = $clog2(PIPE_DLY + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              fill_done_i,
  input logic [ADDR_W-1:0] src_addr_o,
  input logic              rd_ack_o,
  input logic              buf_en_o,
  input logic              buf_wr_o,
  input logic              buf_clr_o,
  input logic              busy_o,
  input logic              proc_o,
  input logic [PIPE_W-1:0] pipe_cnt_o
);
  logic [15:0]       wr_seen_q;
  logic [15:0]       gap_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic              any_read_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen_q   <= '0;
      gap_q       <= '0;
      last_addr_q <= '0;
      any_read_q  <= 1'b0;
    end else begin
      if (buf_en_o) wr_seen_q <= wr_seen_q + 16'd1;
      if (rd_ack_o) begin
        gap_q       <= '0;
        last_addr_q <= src_addr_o;
        any_read_q  <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    rd_ack_o |-> (buf_en_o && buf_wr_o));
  p_en_needs_ack_r3: assert property (@(posedge clk) disable iff (rst)
    buf_en_o |-> rd_ack_o);
  p_first_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_ack_o && !any_read_q) |-> (src_addr_o == '0));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_ack_o && any_read_q) |-> (src_addr_o == last_addr_q + ADDR_W'(1)));
  p_gap_len_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_ack_o && any_read_q) |-> (gap_q == 16'(WAIT_CYC)));
  p_write_budget_r5: assert property (@(posedge clk) disable iff (rst)
    buf_en_o |-> (wr_seen_q < 16'(DEPTH)));
  p_no_en_when_done_r5: assert property (@(posedge clk) disable iff (rst)
    fill_done_i |-> !buf_en_o);
  p_clear_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    buf_clr_o |-> $past(fill_done_i));
  p_clear_single_r7: assert property (@(posedge clk) disable iff (rst)
    buf_clr_o |=> (!buf_clr_o && proc_o));
  p_proc_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
    proc_o |-> !busy_o);
  p_pipe_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (proc_o && $past(proc_o) && $past(pipe_cnt_o) != '0)
      |-> (pipe_cnt_o == $past(pipe_cnt_o) - PIPE_W'(1)));
  p_pipe_floor_r8: assert property (@(posedge clk) disable iff (rst)
    (proc_o && $past(proc_o) && $past(pipe_cnt_o) == '0) |-> (pipe_cnt_o == '0));
endmodule

bind buf_fill_ctrl bfc_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .PIPE_DLY(PIPE_DLY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fill_done_i(fill_done_i),
  .src_addr_o (src_addr_o),
  .rd_ack_o   (rd_ack_o),
  .buf_en_o   (buf_en_o),
  .buf_wr_o   (buf_wr_o),
  .buf_clr_o  (buf_clr_o),
  .busy_o     (busy_o),
  .proc_o     (proc_o),
  .pipe_cnt_o (pipe_cnt_o)
);

// File: tb/test_buf_fill_ctrl.sv
`timescale 1ns/1ps
module test_buf_fill_ctrl;
  localparam int DEPTH    = 20;
  localparam int ADDR_W   = 8;
  localparam int WAIT_CYC = 3;
  localparam int PIPE_DLY = 5;
  localparam int PIPE_W   = $clog2(PIPE_DLY + 1);

  localparam int M_IDLE = 0, M_GAP = 1, M_READ = 2, M_HOLD = 3, M_CLR = 4, M_PROC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic fill_done = 1'b0;
  logic [ADDR_W-1:0] src_addr_o;
  logic rd_ack_o, buf_en_o, buf_wr_o, buf_clr_o, busy_o, proc_o;
  logic [PIPE_W-1:0] pipe_cnt_o;

  always #2.5 clk = ~clk;

  buf_fill_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .PIPE_DLY(PIPE_DLY))
  i_buf_fill_ctrl (
    .clk(clk), .rst(rst), .start(start), .fill_done_i(fill_done),
    .src_addr_o(src_addr_o), .rd_ack_o(rd_ack_o), .buf_en_o(buf_en_o),
    .buf_wr_o(buf_wr_o), .buf_clr_o(buf_clr_o), .busy_o(busy_o),
    .proc_o(proc_o), .pipe_cnt_o(pipe_cnt_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural buffer model
  int  extra_lag = 0;
  int  lag_left  = 0;
  int  b_ptr     = 0;
  int  writes    = 0;
  int  dups      = 0;
  int  clr_count = 0;
  int  hold_cyc  = 0;
  bit  seen [int];

  // behavioural controller model
  int m_state = M_IDLE;
  int m_timer = 0;
  int m_addr  = 0;
  int m_nwr   = 0;
  int m_pipe  = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      b_ptr = 0; lag_left = 0; fill_done <= 1'b0;
      m_state = M_IDLE; m_timer = 0; m_addr = 0; m_nwr = 0; m_pipe = 0;
    end else begin
      if (buf_clr_o) begin
        clr_count++;
        b_ptr = 0; lag_left = 0; fill_done <= 1'b0;
      end else if (buf_en_o && !fill_done) begin
        writes++;
        if (seen.exists(int'(src_addr_o))) dups++;
        seen[int'(src_addr_o)] = 1'b1;
        if (b_ptr == DEPTH - 1) begin
          b_ptr = 0;
          if (extra_lag == 0) fill_done <= 1'b1;
          else lag_left = extra_lag;
        end else b_ptr++;
      end else if (lag_left > 0) begin
        lag_left--;
        if (lag_left == 0) fill_done <= 1'b1;
      end

      case (m_state)
        M_IDLE: if (start) begin m_state = M_GAP; m_timer = WAIT_CYC - 1; end
        M_GAP:  if (m_timer == 0) m_state = M_READ; else m_timer--;
        M_READ: begin
          m_nwr++;
          if (m_nwr == DEPTH) m_state = M_HOLD;
          else begin m_addr++; m_timer = WAIT_CYC - 1; m_state = M_GAP; end
        end
        M_HOLD: if (fill_done) m_state = M_CLR;
        M_CLR:  begin m_state = M_PROC; m_pipe = PIPE_DLY; end
        default: if (m_pipe > 0) m_pipe--;
      endcase
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(src_addr_o) == m_addr, "R4 addr", int'(src_addr_o), m_addr);
      chk(rd_ack_o == (m_state == M_READ), "R3 rd_ack", rd_ack_o, m_state == M_READ);
      chk(buf_en_o == (m_state == M_READ), "R5 buf_en", buf_en_o, m_state == M_READ);
      chk(buf_wr_o == (m_state == M_READ), "R3 buf_wr", buf_wr_o, m_state == M_READ);
      chk(buf_clr_o == (m_state == M_CLR), "R7 buf_clr", buf_clr_o, m_state == M_CLR);
      chk(busy_o == (m_state >= M_GAP && m_state <= M_CLR), "R2 busy", busy_o,
          m_state >= M_GAP && m_state <= M_CLR);
      chk(proc_o == (m_state == M_PROC), "R8 proc", proc_o, m_state == M_PROC);
      chk(int'(pipe_cnt_o) == m_pipe, "R8 pipe_cnt", int'(pipe_cnt_o), m_pipe);
      if (busy_o && !rd_ack_o && !buf_clr_o && writes == DEPTH) hold_cyc++;
    end
  end

  task automatic check_reset_outputs();
    chk(src_addr_o == '0 && pipe_cnt_o == '0, "R1 addr/pipe", int'(src_addr_o), 0);
    chk({rd_ack_o, buf_en_o, buf_wr_o, buf_clr_o, busy_o, proc_o} == 6'b0,
        "R1 strobes", int'({rd_ack_o, buf_en_o, buf_wr_o, buf_clr_o, busy_o, proc_o}), 0);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_proc();
    for (int i = 0; i < 2000 && !proc_o; i++) @(negedge clk);
  endtask

  task automatic run_fill(input int lag, input bit spurious);
    extra_lag = lag;
    pulse_start();
    if (spurious) begin
      repeat (WAIT_CYC + 2) @(negedge clk);
      start = 1'b1;                        // R9: ignored mid-fill
      @(negedge clk) start = 1'b0;
    end
    wait_proc();
    repeat (PIPE_DLY + 2) @(negedge clk);
    chk(writes == DEPTH, "R5 write total", writes, DEPTH);
    chk(dups == 0, "R4 duplicate addresses", dups, 0);
    chk(clr_count == 1, "R7 clear count", clr_count, 1);
    chk(hold_cyc == lag + 1, "R6 hold length", hold_cyc, lag + 1);
    chk(proc_o && pipe_cnt_o == '0, "R8 final", int'(pipe_cnt_o), 0);
    start = 1'b1;                          // R9: ignored in processing
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(proc_o && !busy_o && !rd_ack_o, "R9 start in processing", proc_o, 1);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_outputs();
    writes = 0; dups = 0; clr_count = 0; hold_cyc = 0;
    seen.delete();
    rst = 1'b0;
    @(negedge clk);
    check_reset_outputs();                 // R1 first cycle after release
  endtask

  initial begin
    do_reset();
    run_fill(0, 1'b0);
    do_reset();
    run_fill(4, 1'b1);
    do_reset();
    run_fill(1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles >= 20000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule